// File: doc/BRIEF.md
# Multi-mode spike train decoder

This block turns a stream of spike pulses back into an 8-bit value. Three schemes are available, and a 2-bit mode input selects one of them. Rate mode counts spikes over a window. Latency mode measures how early in a window the first spike arrives. Delta mode keeps a signed leaky accumulator: spikes on a positive input push it up, spikes on a negative input push it down, and the block reports it as an offset-binary byte.

An internal counter sets the window timing. It restarts each time the block is enabled. At the end of every window the block publishes a fresh value and pulses a valid strobe. Dropping the enable publishes whatever the decoder holds at that moment, so a host can freeze a partial result. Both spike inputs may be asynchronous. A sticky overflow flag records any saturation. The raw accumulator is exposed so that delta decoding can be watched between publications.

Top module: `spike_decoder`

## Requirements
- R1: In rate mode (mode 2'b00) the published value is the number of synchronized rising edges of the positive input seen in the window. This includes an edge that is consumed in the window's last cycle. The count starts again from zero in the next window.
- R2: The rate count saturates at 255. A rising edge that arrives while the count is already 255 sets the overflow output.
- R3: In latency mode (mode 2'b01) the published value is 255 minus the window index of the first synchronized rising edge. The first cycle after enable or rollover has index 0. Later edges in the same window have no effect. The value is 0 if the index exceeds 255.
- R4: In latency mode a window with no rising edge publishes 0.
- R5: In delta mode (mode 2'b10) the 16-bit two's-complement accumulator, visible on acc_state, changes by +step on each positive edge and by −step on each negative edge. Edges on both inputs in the same cycle cancel. The published value is the accumulator's high byte with its top bit inverted, so zero reads 0x80.
- R6: Each enabled delta-mode cycle, after any step is applied, the accumulator moves toward zero by the leak amount. It stops at exactly zero and never changes sign through leak.
- R7: The accumulator clamps at +32767 and −32768. Any clamp sets overflow. Overflow stays set until reset.
- R8: When enable goes from 1 to 0, the in-flight value is published on the next cycle with a valid pulse. That value is the count so far, the latency result so far, or the current accumulator byte.
- R9: dec_valid is high for one cycle per publication. With window length W, successive window publications are exactly W cycles apart.
- R10: Each spike input passes through two synchronizing flops before edge detection. An edge is consumed two clock edges after the input is sampled high, and a pulse held high for many cycles counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the window and decoder; falling edge snapshots |
| mode | input | 2 | 00 rate, 01 latency, 10 delta, 11 publishes zero |
| pos_spike | input | 1 | Positive spike input (asynchronous) |
| neg_spike | input | 1 | Negative spike input, delta mode only (asynchronous) |
| win_len | input | WIN_W (10) | Window length in cycles; 0 acts as 1 |
| step | input | STEP_W (8) | Accumulator change per delta spike |
| leak | input | STEP_W (8) | Per-cycle decay toward zero in delta mode |
| dec_value | output | VAL_W (8) | Last published decoded value |
| dec_valid | output | 1 | One-cycle pulse when dec_value is updated |
| overflow | output | 1 | Sticky saturation flag |
| acc_state | output | ACC_W (16) | Raw delta accumulator |

## Verification
The collision that matters is a spike edge consumed in the same cycle the window rolls over. In that cycle the published value must include the edge, and the freshly cleared counter must not. The bench provokes this by raising the positive input exactly three edges before the last window index. It then expects a rate count of 1 followed by 0 in the next window, and a latency result of 255 minus the last index. A second collision is positive and negative edges landing together in delta mode, which must leave the accumulator unchanged, along with a leak step that coincides with a spike step.

// File: rtl/spk_dec_pkg.sv
package spk_dec_pkg;

   typedef enum logic [1:0] {
      MODE_RATE  = 2'b00,
      MODE_LAT   = 2'b01,
      MODE_DELTA = 2'b10,
      MODE_RSVD  = 2'b11
   } dec_mode_e;

endpackage

// File: rtl/spk_edge_sync.sv
// Multi-stage synchronizer followed by a rising-edge detector.
module spk_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din};
   end

   // sh_q[STAGES-1] is the last synchronizer stage; sh_q[STAGES] its delayed copy
   assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/spk_window.sv
// Window index counter; restarts while not running and after the last index.
module spk_window #(
   parameter int WIN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [WIN_W-1:0] win_len,
   output logic [WIN_W-1:0] idx,
   output logic             last
);

   logic [WIN_W:0] nxt;

   assign nxt  = {1'b0, idx} + (WIN_W+1)'(1);
   assign last = run && (nxt >= {1'b0, win_len});

   always_ff @(posedge clk) begin
      if (!rst_n)         idx <= '0;
      else if (!run)      idx <= '0;
      else if (last)      idx <= '0;
      else                idx <= nxt[WIN_W-1:0];
   end

endmodule

// File: rtl/spk_delta_acc.sv
// Signed saturating accumulator with leak toward zero.
module spk_delta_acc #(
   parameter int ACC_W  = 16,
   parameter int STEP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              up,
   input  logic              dn,
   input  logic [STEP_W-1:0] step,
   input  logic [STEP_W-1:0] leak,
   output logic [ACC_W-1:0]  acc,
   output logic [ACC_W-1:0]  acc_next,
   output logic              clamped
);

   localparam int EW = ACC_W + 2;
   localparam logic signed [EW-1:0] MAXV = signed'({3'b000, {(ACC_W-1){1'b1}}});
   localparam logic signed [EW-1:0] MINV = signed'({3'b111, {(ACC_W-1){1'b0}}});

   logic signed [EW-1:0] ext_acc, ext_step, ext_leak, sum, clip, leaked;
   logic                 hit;

   assign ext_acc  = {{2{acc[ACC_W-1]}}, acc};
   assign ext_step = {{(EW-STEP_W){1'b0}}, step};
   assign ext_leak = {{(EW-STEP_W){1'b0}}, leak};

   always_comb begin
      sum = ext_acc;
      if (up && !dn)      sum = ext_acc + ext_step;
      else if (dn && !up) sum = ext_acc - ext_step;

      hit  = 1'b0;
      clip = sum;
      if (sum > MAXV) begin
         clip = MAXV;
         hit  = 1'b1;
      end else if (sum < MINV) begin
         clip = MINV;
         hit  = 1'b1;
      end

      if (!clip[EW-1]) leaked = (clip <= ext_leak)  ? '0 : clip - ext_leak;
      else             leaked = (-clip <= ext_leak) ? '0 : clip + ext_leak;
   end

   assign acc_next = leaked[ACC_W-1:0];
   assign clamped  = run && hit;

   always_ff @(posedge clk) begin
      if (!rst_n)   acc <= '0;
      else if (run) acc <= acc_next;
   end

endmodule

// File: rtl/spike_decoder.sv
// Multi-mode spike train decoder: rate, first-spike latency, leaky delta.
module spike_decoder
   import spk_dec_pkg::*;
#(
   parameter int VAL_W       = 8,
   parameter int WIN_W       = 10,
   parameter int ACC_W       = 16,
   parameter int STEP_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [1:0]        mode,
   input  logic              pos_spike,
   input  logic              neg_spike,
   input  logic [WIN_W-1:0]  win_len,
   input  logic [STEP_W-1:0] step,
   input  logic [STEP_W-1:0] leak,
   output logic [VAL_W-1:0]  dec_value,
   output logic              dec_valid,
   output logic              overflow,
   output logic [ACC_W-1:0]  acc_state
);

   localparam int FULL_I = (1 << VAL_W) - 1;

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spike_decoder: SYNC_STAGES must be at least 2");
   end
   if (ACC_W < VAL_W + 1) begin : g_bad_acc
      $error("spike_decoder: ACC_W must exceed VAL_W");
   end
   if (ACC_W < STEP_W + 2) begin : g_bad_step
      $error("spike_decoder: ACC_W too narrow for STEP_W");
   end

   function automatic logic [VAL_W-1:0] lat_map(input logic [WIN_W-1:0] i);
      if (int'(i) > FULL_I) return '0;
      return VAL_W'(FULL_I - int'(i));
   endfunction

   function automatic logic [VAL_W-1:0] to_offset(input logic [ACC_W-1:0] a);
      return {~a[ACC_W-1], a[ACC_W-2 -: VAL_W-1]};
   endfunction

   dec_mode_e cur_mode;
   assign cur_mode = dec_mode_e'(mode);

   // ---------------- input synchronizers ----------------
   logic [1:0] spk_in, spk_rise;
   assign spk_in = {neg_spike, pos_spike};

   for (genvar g = 0; g < 2; g++) begin : g_sync
      spk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (spk_in[g]),
         .rise (spk_rise[g])
      );
   end

   logic rise_pos, rise_neg;
   assign rise_pos = spk_rise[0];
   assign rise_neg = spk_rise[1];

   // ---------------- enable edge ----------------
   logic en_q, fall;
   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= enable;
   end
   assign fall = en_q & ~enable;

   // ---------------- window ----------------
   logic [WIN_W-1:0] win_idx;
   logic             win_last;

   spk_window #(.WIN_W(WIN_W)) u_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (enable),
      .win_len(win_len),
      .idx    (win_idx),
      .last   (win_last)
   );

   // ---------------- rate counter ----------------
   logic [VAL_W-1:0] rcnt, rate_next;
   logic             rate_sat;

   assign rate_sat  = &rcnt;
   assign rate_next = (rise_pos && !rate_sat) ? rcnt + VAL_W'(1) : rcnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                 rcnt <= '0;
      else if (!enable || win_last) rcnt <= '0;
      else                        rcnt <= rate_next;
   end

   // ---------------- first-spike latency ----------------
   logic             seen;
   logic [WIN_W-1:0] first_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen      <= 1'b0;
         first_idx <= '0;
      end else if (!enable || win_last) begin
         seen      <= 1'b0;
      end else if (rise_pos && !seen) begin
         seen      <= 1'b1;
         first_idx <= win_idx;
      end
   end

   logic [VAL_W-1:0] lat_end, lat_snap;
   always_comb begin
      if (seen)          lat_end = lat_map(first_idx);
      else if (rise_pos) lat_end = lat_map(win_idx);
      else               lat_end = '0;
      lat_snap = seen ? lat_map(first_idx) : '0;
   end

   // ---------------- delta accumulator ----------------
   logic [ACC_W-1:0] acc_q, acc_nx;
   logic             acc_clamp;
   logic             delta_run;

   assign delta_run = enable && (cur_mode == MODE_DELTA);

   spk_delta_acc #(.ACC_W(ACC_W), .STEP_W(STEP_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (delta_run),
      .up      (rise_pos),
      .dn      (rise_neg),
      .step    (step),
      .leak    (leak),
      .acc     (acc_q),
      .acc_next(acc_nx),
      .clamped (acc_clamp)
   );

   assign acc_state = acc_q;

   // ---------------- publication ----------------
   logic             pub;
   logic [VAL_W-1:0] pub_val;

   assign pub = win_last | fall;

   always_comb begin
      case (cur_mode)
         MODE_RATE:  pub_val = fall ? rcnt : rate_next;
         MODE_LAT:   pub_val = fall ? lat_snap : lat_end;
         MODE_DELTA: pub_val = fall ? to_offset(acc_q) : to_offset(acc_nx);
         default:    pub_val = '0;
      endcase
   end

   logic ovf_evt;
   assign ovf_evt = (enable && cur_mode == MODE_RATE && rise_pos && rate_sat) || acc_clamp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_value <= '0;
         overflow  <= 1'b0;
      end else begin
         dec_valid <= pub;
         if (pub) dec_value <= pub_val;
         if (ovf_evt) overflow <= 1'b1;
      end
   end

endmodule

// File: rtl/spike_decoder_chk.sv
// Property checker for spike_decoder, attached by bind below.
module spike_decoder_chk #(
   parameter int ACC_W = 16,
   parameter int VAL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic [1:0]       mode,
   input logic [VAL_W-1:0] dec_value,
   input logic             dec_valid,
   input logic             overflow,
   input logic [ACC_W-1:0] acc_state,
   input logic             rise_pos,
   input logic             rise_neg
);

   logic en_prev;
   always_ff @(posedge clk) begin
      if (!rst_n) en_prev <= 1'b0;
      else        en_prev <= enable;
   end

   // R8: a falling enable is followed by a publication
   a_r8_snapshot_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (en_prev && !enable) |=> dec_valid);

   // R7: overflow is sticky
   a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R5: a delta publication matches the accumulator's offset-binary high byte
   a_r5_delta_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && $past(mode) == 2'b10) |->
         dec_value == {~acc_state[ACC_W-1], acc_state[ACC_W-2 -: VAL_W-1]});

   // R6: leak alone never turns a non-negative accumulator negative
   a_r6_leak_no_cross_pos: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mode == 2'b10 && !rise_pos && !rise_neg && !acc_state[ACC_W-1])
         |=> !acc_state[ACC_W-1]);

   // R6: leak alone never turns a negative accumulator positive
   a_r6_leak_no_cross_neg: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && mode == 2'b10 && !rise_pos && !rise_neg && acc_state[ACC_W-1])
         |=> (acc_state[ACC_W-1] || acc_state == '0));

endmodule

bind spike_decoder spike_decoder_chk #(.ACC_W(ACC_W), .VAL_W(VAL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .mode     (mode),
   .dec_value(dec_value),
   .dec_valid(dec_valid),
   .overflow (overflow),
   .acc_state(acc_state),
   .rise_pos (spk_rise[0]),
   .rise_neg (spk_rise[1])
);

// File: tb/spike_decoder_bench.sv
module spike_decoder_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       enable;
   logic [1:0] mode;
   logic       pos_spike, neg_spike;
   logic [9:0] win_len;
   logic [7:0] step_amt, leak_amt;
   logic [7:0] dec_value;
   logic       dec_valid;
   logic       overflow;
   logic [15:0] acc_state;

   int total = 0;
   int fails = 0;

   always #10 clk = ~clk;   // 50 MHz

   spike_decoder u_spike_decoder (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .mode     (mode),
      .pos_spike(pos_spike),
      .neg_spike(neg_spike),
      .win_len  (win_len),
      .step     (step_amt),
      .leak     (leak_amt),
      .dec_value(dec_value),
      .dec_valid(dec_valid),
      .overflow (overflow),
      .acc_state(acc_state)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; enable = 1'b0; mode = 2'b00;
      pos_spike = 1'b0; neg_spike = 1'b0;
      win_len = 10'd16; step_amt = 8'd0; leak_amt = 8'd0;
      cyc(5);
      rst_n = 1'b1;
      cyc(1);
   endtask

   // leaves the bench at the negedge where enable was raised
   task automatic start(input logic [1:0] m, input int w);
      enable = 1'b0;
      cyc(4);
      mode = m;
      win_len = 10'(w);
      enable = 1'b1;
   endtask

   task automatic pulse_pos();
      pos_spike = 1'b1; cyc(1); pos_spike = 1'b0; cyc(2);
   endtask

   task automatic pulse_neg();
      neg_spike = 1'b1; cyc(1); neg_spike = 1'b0; cyc(2);
   endtask

   task automatic wait_valid(output int v, output int n);
      v = -1;
      n = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         n++;
         if (dec_valid) begin
            v = int'(dec_value);
            break;
         end
      end
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("reset dec_value", int'(dec_value), 0);
      chk("reset dec_valid", int'(dec_valid), 0);
      chk("reset overflow", int'(overflow), 0);
      chk("reset acc_state", int'(acc_state), 0);
   endtask

   // R1 R9 R10: five short pulses and one long pulse count as six
   task automatic t_rate();
      int v, n;
      do_reset();
      start(2'b00, 60);
      for (int k = 0; k < 5; k++) pulse_pos();
      pos_spike = 1'b1; cyc(10); pos_spike = 1'b0; cyc(3);
      wait_valid(v, n);
      chk("R1 R10 rate count", v, 6);
      wait_valid(v, n);
      chk("R1 empty window", v, 0);
      chk("R9 window spacing", n, 60);
      cyc(1);
      chk("R9 valid one cycle", int'(dec_valid), 0);
   endtask

   // R1 R3: edge consumed in the window's last cycle
   task automatic t_last_cycle();
      int v, n;
      do_reset();
      start(2'b00, 20);
      cyc(17);
      pos_spike = 1'b1; cyc(1); pos_spike = 1'b0;
      wait_valid(v, n);
      chk("R1 last-cycle edge counted", v, 1);
      wait_valid(v, n);
      chk("R1 last-cycle edge not carried", v, 0);
      start(2'b01, 20);
      cyc(17);
      pos_spike = 1'b1; cyc(1); pos_spike = 1'b0;
      wait_valid(v, n);
      chk("R3 latency at last index", v, 236);
   endtask

   // R2: saturation at 255 sets overflow
   task automatic t_rate_sat();
      int v, n;
      do_reset();
      start(2'b00, 1000);
      for (int k = 0; k < 300; k++) pulse_pos();
      wait_valid(v, n);
      chk("R2 rate saturates", v, 255);
      chk("R2 overflow set", int'(overflow), 1);
   endtask

   // R3 R4 R10: edge raised before window edge 5 is consumed at index 7
   task automatic t_latency();
      int v, n;
      do_reset();
      start(2'b01, 40);
      cyc(5);
      pulse_pos();
      cyc(6);
      pulse_pos();   // later edge in same window is ignored
      wait_valid(v, n);
      chk("R3 R10 latency value", v, 248);
      wait_valid(v, n);
      chk("R4 no spike publishes zero", v, 0);
   endtask

   // R5: step up/down, cancelling edges, offset-binary byte
   task automatic t_delta();
      int v, n;
      do_reset();
      step_amt = 8'd100;
      start(2'b10, 200);
      for (int k = 0; k < 3; k++) pulse_pos();
      cyc(3);
      chk("R5 accumulator after +3 steps", int'($signed(acc_state)), 300);
      wait_valid(v, n);
      chk("R5 offset byte positive", v, 8'h81);
      for (int k = 0; k < 5; k++) pulse_neg();
      pos_spike = 1'b1; neg_spike = 1'b1; cyc(1);
      pos_spike = 1'b0; neg_spike = 1'b0; cyc(4);
      chk("R5 simultaneous edges cancel", int'($signed(acc_state)), -200);
      wait_valid(v, n);
      chk("R5 offset byte negative", v, 8'h7F);
   endtask

   // R6: leak decays to exactly zero without crossing
   task automatic t_leak();
      int mx, mn, crossed;
      do_reset();
      step_amt = 8'd100;
      leak_amt = 8'd7;
      start(2'b10, 500);
      mx = 0; crossed = 0;
      pos_spike = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (i == 0) pos_spike = 1'b0;
         if (int'($signed(acc_state)) > mx) mx = int'($signed(acc_state));
         if (acc_state[15]) crossed = 1;
      end
      chk("R6 peak is step minus leak", mx, 93);
      chk("R6 positive never crosses", crossed, 0);
      chk("R6 settles at zero", int'(acc_state), 0);
      mn = 0; crossed = 0;
      neg_spike = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (i == 0) neg_spike = 1'b0;
         if (int'($signed(acc_state)) < mn) mn = int'($signed(acc_state));
         if (int'($signed(acc_state)) > 0) crossed = 1;
      end
      chk("R6 trough is minus step plus leak", mn, -93);
      chk("R6 negative never crosses", crossed, 0);
      chk("R6 settles at zero from below", int'(acc_state), 0);
   endtask

   // R7 R8: clamps, overflow, snapshot on disable
   task automatic t_clamp();
      int v, n;
      do_reset();
      step_amt = 8'd255;
      start(2'b10, 1000);
      for (int k = 0; k < 130; k++) pulse_pos();
      cyc(3);
      chk("R7 clamp high", int'(acc_state), 32767);
      chk("R7 overflow on clamp", int'(overflow), 1);
      enable = 1'b0;
      wait_valid(v, n);
      chk("R8 delta snapshot", v, 8'hFF);
      chk("R8 snapshot latency", n, 1);
      do_reset();
      step_amt = 8'd255;
      start(2'b10, 1000);
      for (int k = 0; k < 130; k++) pulse_neg();
      cyc(3);
      chk("R7 clamp low", int'(acc_state), 32768);
      enable = 1'b0;
      wait_valid(v, n);
      chk("R8 delta snapshot low", v, 0);
      cyc(5);
      chk("R7 overflow stays set", int'(overflow), 1);
   endtask

   // R8: snapshots in rate and latency modes
   task automatic t_snapshot();
      int v, n;
      do_reset();
      start(2'b00, 500);
      for (int k = 0; k < 4; k++) pulse_pos();
      cyc(5);
      enable = 1'b0;
      wait_valid(v, n);
      chk("R8 rate snapshot", v, 4);
      cyc(1);
      chk("R9 snapshot valid one cycle", int'(dec_valid), 0);
      start(2'b01, 500);
      cyc(8);
      pulse_pos();
      cyc(5);
      enable = 1'b0;
      wait_valid(v, n);
      chk("R8 latency snapshot", v, 245);
   endtask

   initial begin
      t_reset_state();
      t_rate();
      t_last_cycle();
      t_rate_sat();
      t_latency();
      t_delta();
      t_leak();
      t_clamp();
      t_snapshot();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule